// File: doc/BRIEF.md
# FIFO Threshold Flag Unit

This block sits beside a FIFO's storage and pointer logic and turns the current fill level into two active-low early-warning flags. A near-full flag drops once the level comes within a programmable distance of the FIFO capacity. A near-empty flag drops once the level falls under a second programmable distance. The near-full flag is registered on the write clock from the write-side level. The near-empty flag is registered on the read clock from the read-side level.

The two distances are held in a full offset register and an empty offset register. A master reset fills both with one of two default values. The configuration select line, sampled during that reset, picks the value and also fixes how the offsets may be reprogrammed until the next master reset. In parallel mode, data-bus words are written slice by slice on the write clock. In serial mode, one bit per write-clock edge is shifted in. In both modes the offsets can be read back slice by slice on the read clock. A partial reset rewinds the slice sequencers and leaves the offsets and the programming mode as they were.

Top module: `thr_flag_unit`

## Requirements
- R1: While `mrst_n` is low, `cfg_sel` is sampled on each write-clock edge. A 0 loads both offsets with 127 and selects serial programming. A 1 loads both offsets with 1023 and selects parallel programming.
- R2: `near_full_n` is registered on `wr_clk`. After an edge it is low exactly when the `wr_level` sampled at that edge plus the full offset exceeds DEPTH.
- R3: `near_empty_n` is registered on `rd_clk`. After an edge it is low exactly when the `rd_level` sampled at that edge is below the empty offset.
- R4: In parallel mode, each `wr_clk` edge with `cfg_sel` and `wr_en` both high writes `din` into the next slice. The fixed order is: empty offset bits 8:0, empty offset bits 14:9, full offset bits 8:0, full offset bits 14:9. After the last slice the order starts again at the first.
- R5: Each `rd_clk` edge with `cfg_sel` and `rd_en` both high places the next offset slice on `dout`, using the R4 order, with unused upper bits zero. On any other edge `dout` holds its value.
- R6: In serial mode, each `wr_clk` edge with `ser_en` high shifts `ser_in` into the 30-bit chain {full, empty} from the top. After 30 shifts, the first bit sent is empty offset bit 0 and the last bit sent is full offset bit 14.
- R7: In serial mode, parallel writes leave the offsets unchanged. In parallel mode, `ser_en` leaves the offsets unchanged.
- R8: While `prst_n` is low and `mrst_n` is high, the offsets and the programming mode keep their values. Both slice sequencers return to the first slice.
- R9: While `mrst_n` is low, each clock edge forces `near_full_n` high, `near_empty_n` low and `dout` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock; offset programming and near-full flag |
| rd_clk | input | 1 | Read clock; offset read-back and near-empty flag |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| cfg_sel | input | 1 | Default/mode select during master reset; offset access select afterwards |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset bit |
| din | input | DATA_W | Parallel offset slice |
| wr_en | input | 1 | Write enable for parallel offset load |
| rd_en | input | 1 | Read enable for offset read-back |
| wr_level | input | CNT_W | FIFO occupancy as seen in the write domain |
| rd_level | input | CNT_W | FIFO occupancy as seen in the read domain |
| dout | output | DATA_W | Read-back offset slice |
| near_full_n | output | 1 | Near-full flag, active low |
| near_empty_n | output | 1 | Near-empty flag, active low |

## Verification
The bench drives the fill level to the exact thresholds and to one step past them (level = DEPTH - full offset, level = empty offset - 1), where an off-by-one comparison or a subtraction that underflows gives a flag one step late or early. It loads random offset pairs in slices and reads them back, so a slice order that is swapped or that does not wrap shows up as misplaced bits. It sends a partial reset in the middle of a slice sequence and then expects the next write to land in the first slice with the offsets intact; a design that clears the offsets or keeps its pointer would fail this. It also drives serial traffic in parallel mode, parallel traffic in serial mode, and serial streams with gaps, which catch a mode that is not latched or a shift that runs in the wrong direction.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic {
        PROG_SERIAL   = 1'b0,
        PROG_PARALLEL = 1'b1
    } prog_mode_e;

    // number of data-bus slices needed to cover one offset register
    function automatic int slice_count(input int ofs_w, input int data_w);
        return (ofs_w + data_w - 1) / data_w;
    endfunction

endpackage

// File: rtl/thr_ofs_regs.sv
module thr_ofs_regs
    import thr_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OFS_W  = 15,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              cfg_sel,
    input  logic              ser_en,
    input  logic              ser_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  full_ofs,
    output logic [OFS_W-1:0]  empty_ofs,
    output prog_mode_e        prog_mode
);

    localparam int SLICES = slice_count(OFS_W, DATA_W);
    localparam int PAD_W  = SLICES * DATA_W;
    localparam int SEQ_N  = 2 * SLICES;
    localparam int SEQ_W  = (SEQ_N > 1) ? $clog2(SEQ_N) : 1;
    localparam int CAT_W  = 2 * OFS_W;

    typedef struct packed {
        logic [OFS_W-1:0] full;
        logic [OFS_W-1:0] empty;
        prog_mode_e       mode;
        logic [SEQ_W-1:0] seq;
    } ofs_state_t;

    ofs_state_t st_d, st_q;
    logic [PAD_W-1:0] pad;
    logic [CAT_W-1:0] chain;
    logic             hi_sel;
    int               slot;

    always_comb begin
        st_d   = st_q;
        chain  = {st_q.full, st_q.empty};
        hi_sel = (int'(st_q.seq) >= SLICES);
        slot   = hi_sel ? int'(st_q.seq) - SLICES : int'(st_q.seq);
        pad    = hi_sel ? PAD_W'(st_q.full) : PAD_W'(st_q.empty);

        if (!mrst_n) begin
            st_d.mode  = cfg_sel ? PROG_PARALLEL : PROG_SERIAL;
            st_d.full  = cfg_sel ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO);
            st_d.empty = cfg_sel ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO);
            st_d.seq   = '0;
        end else if (!prst_n) begin
            st_d.seq = '0;
        end else if (st_q.mode == PROG_SERIAL) begin
            if (ser_en) begin
                chain      = {ser_in, chain[CAT_W-1:1]};
                st_d.full  = chain[CAT_W-1:OFS_W];
                st_d.empty = chain[OFS_W-1:0];
            end
        end else if (cfg_sel && wr_en) begin
            pad[slot*DATA_W +: DATA_W] = din;
            if (hi_sel) st_d.full  = pad[OFS_W-1:0];
            else        st_d.empty = pad[OFS_W-1:0];
            st_d.seq = (int'(st_q.seq) == SEQ_N - 1) ? '0 : st_q.seq + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign full_ofs  = st_q.full;
    assign empty_ofs = st_q.empty;
    assign prog_mode = st_q.mode;

endmodule

// File: rtl/thr_readback.sv
module thr_readback
    import thr_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OFS_W  = 15
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              cfg_sel,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  full_ofs,
    input  logic [OFS_W-1:0]  empty_ofs,
    output logic [DATA_W-1:0] dout
);

    localparam int SLICES = slice_count(OFS_W, DATA_W);
    localparam int PAD_W  = SLICES * DATA_W;
    localparam int SEQ_N  = 2 * SLICES;
    localparam int SEQ_W  = (SEQ_N > 1) ? $clog2(SEQ_N) : 1;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] dout;
    } rb_state_t;

    rb_state_t        st_d, st_q;
    logic [PAD_W-1:0] pad;
    logic             hi_sel;
    int               slot;

    always_comb begin
        st_d   = st_q;
        hi_sel = (int'(st_q.seq) >= SLICES);
        slot   = hi_sel ? int'(st_q.seq) - SLICES : int'(st_q.seq);
        pad    = hi_sel ? PAD_W'(full_ofs) : PAD_W'(empty_ofs);

        if (!mrst_n) begin
            st_d.seq  = '0;
            st_d.dout = '0;
        end else if (!prst_n) begin
            st_d.seq = '0;
        end else if (cfg_sel && rd_en) begin
            st_d.dout = pad[slot*DATA_W +: DATA_W];
            st_d.seq  = (int'(st_q.seq) == SEQ_N - 1) ? '0 : st_q.seq + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.dout;

endmodule

// File: rtl/thr_flag_cmp.sv
module thr_flag_cmp #(
    parameter int DEPTH       = 32768,
    parameter int CNT_W       = 16,
    parameter int OFS_W       = 15,
    parameter bit NEAR_FULL   = 1'b1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic [CNT_W-1:0] level,
    input  logic [OFS_W-1:0] ofs,
    output logic             flag_n
);

    localparam int EXT_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 2;

    typedef struct packed {
        logic flag_n;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       hit;
    logic       rst_val;

    generate
        if (NEAR_FULL) begin : g_full
            // sum form avoids an underflowing capacity-minus-offset term
            assign hit     = (EXT_W'(level) + EXT_W'(ofs)) > EXT_W'(DEPTH);
            assign rst_val = 1'b1;
        end else begin : g_empty
            assign hit     = EXT_W'(level) < EXT_W'(ofs);
            assign rst_val = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.flag_n = mrst_n ? ~hit : rst_val;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag_n = st_q.flag_n;

endmodule

// File: rtl/thr_flag_unit.sv
module thr_flag_unit
    import thr_pkg::*;
#(
    parameter  int DEPTH  = 32768,
    parameter  int DATA_W = 9,
    parameter  int OFS_W  = 15,
    parameter  int DEF_LO = 127,
    parameter  int DEF_HI = 1023,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              cfg_sel,
    input  logic              ser_en,
    input  logic              ser_in,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  wr_level,
    input  logic [CNT_W-1:0]  rd_level,
    output logic [DATA_W-1:0] dout,
    output logic              near_full_n,
    output logic              near_empty_n
);

    logic [OFS_W-1:0] full_ofs;
    logic [OFS_W-1:0] empty_ofs;
    prog_mode_e       prog_mode;

    thr_ofs_regs #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W),
        .DEF_LO (DEF_LO),
        .DEF_HI (DEF_HI)
    ) i_ofs_regs (
        .clk       (wr_clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .cfg_sel   (cfg_sel),
        .ser_en    (ser_en),
        .ser_in    (ser_in),
        .wr_en     (wr_en),
        .din       (din),
        .full_ofs  (full_ofs),
        .empty_ofs (empty_ofs),
        .prog_mode (prog_mode)
    );

    thr_readback #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) i_readback (
        .clk       (rd_clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .cfg_sel   (cfg_sel),
        .rd_en     (rd_en),
        .full_ofs  (full_ofs),
        .empty_ofs (empty_ofs),
        .dout      (dout)
    );

    thr_flag_cmp #(
        .DEPTH     (DEPTH),
        .CNT_W     (CNT_W),
        .OFS_W     (OFS_W),
        .NEAR_FULL (1'b1)
    ) i_full_cmp (
        .clk    (wr_clk),
        .mrst_n (mrst_n),
        .level  (wr_level),
        .ofs    (full_ofs),
        .flag_n (near_full_n)
    );

    thr_flag_cmp #(
        .DEPTH     (DEPTH),
        .CNT_W     (CNT_W),
        .OFS_W     (OFS_W),
        .NEAR_FULL (1'b0)
    ) i_empty_cmp (
        .clk    (rd_clk),
        .mrst_n (mrst_n),
        .level  (rd_level),
        .ofs    (empty_ofs),
        .flag_n (near_empty_n)
    );

endmodule

// File: rtl/thr_flag_unit_chk.sv
module thr_flag_unit_chk
    import thr_pkg::*;
#(
    parameter int DEPTH  = 32768,
    parameter int DATA_W = 9,
    parameter int OFS_W  = 15,
    parameter int CNT_W  = 16
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              mrst_n,
    input logic              prst_n,
    input logic              cfg_sel,
    input logic              ser_en,
    input logic              wr_en,
    input logic              rd_en,
    input logic [CNT_W-1:0]  wr_level,
    input logic [CNT_W-1:0]  rd_level,
    input logic [DATA_W-1:0] dout,
    input logic              near_full_n,
    input logic              near_empty_n,
    input logic [OFS_W-1:0]  full_ofs,
    input logic [OFS_W-1:0]  empty_ofs,
    input prog_mode_e        prog_mode
);

    localparam int EXT_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 2;

    a_r9_reset_full_high: assert property (@(posedge wr_clk)
        !mrst_n |=> near_full_n);

    a_r9_reset_read_side: assert property (@(posedge rd_clk)
        !mrst_n |=> (!near_empty_n && dout == '0));

    a_r2_full_threshold: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        $past(mrst_n) |->
            (near_full_n == !((EXT_W'($past(wr_level)) + EXT_W'($past(full_ofs))) > EXT_W'(DEPTH))));

    a_r3_empty_threshold: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        $past(mrst_n) |->
            (near_empty_n == !(EXT_W'($past(rd_level)) < EXT_W'($past(empty_ofs)))));

    a_r5_dout_holds: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        ($past(mrst_n) && !$past(cfg_sel && rd_en)) |-> $stable(dout));

    a_r7_serial_ignores_parallel: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        ($past(mrst_n) && prog_mode == PROG_SERIAL && !$past(ser_en))
            |-> $stable({full_ofs, empty_ofs}));

    a_r7_parallel_ignores_serial: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        ($past(mrst_n) && prog_mode == PROG_PARALLEL && !$past(cfg_sel && wr_en))
            |-> $stable({full_ofs, empty_ofs}));

    a_r8_partial_keeps_offsets: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        !prst_n |=> ($stable({full_ofs, empty_ofs}) && $stable(prog_mode)));

endmodule

bind thr_flag_unit thr_flag_unit_chk #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W),
    .CNT_W  (CNT_W)
) i_chk (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .mrst_n       (mrst_n),
    .prst_n       (prst_n),
    .cfg_sel      (cfg_sel),
    .ser_en       (ser_en),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .wr_level     (wr_level),
    .rd_level     (rd_level),
    .dout         (dout),
    .near_full_n  (near_full_n),
    .near_empty_n (near_empty_n),
    .full_ofs     (full_ofs),
    .empty_ofs    (empty_ofs),
    .prog_mode    (prog_mode)
);

// File: tb/test_thr_flag_unit.sv
module test_thr_flag_unit;

    localparam int DEPTH  = 32768;
    localparam int DATA_W = 9;
    localparam int OFS_W  = 15;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              mrst_n = 1'b0;
    logic              prst_n = 1'b1;
    logic              cfg_sel = 1'b0;
    logic              ser_en = 1'b0;
    logic              ser_in = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [CNT_W-1:0]  wr_level = '0;
    logic [CNT_W-1:0]  rd_level = '0;
    logic [DATA_W-1:0] dout;
    logic              near_full_n;
    logic              near_empty_n;

    always #10 clk = ~clk;

    thr_flag_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W), .OFS_W(OFS_W)) i_thr_flag_unit (
        .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_sel(cfg_sel), .ser_en(ser_en), .ser_in(ser_in), .din(din),
        .wr_en(wr_en), .rd_en(rd_en), .wr_level(wr_level), .rd_level(rd_level),
        .dout(dout), .near_full_n(near_full_n), .near_empty_n(near_empty_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    int  m_ref, n_ref, wseq, rseq;
    bit  par_mode;
    logic [DATA_W-1:0] dout_ref;

    function automatic bit exp_full_n(int lvl, int m);
        return !(lvl + m > DEPTH);
    endfunction

    function automatic bit exp_empty_n(int lvl, int n);
        return !(lvl < n);
    endfunction

    function automatic logic [DATA_W-1:0] ref_slice(int k);
        int off;
        off = (k < 2) ? n_ref : m_ref;
        return DATA_W'((off >> ((k % 2) * DATA_W)) & 9'h1FF);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_mrst(bit sel);
        mrst_n = 0; cfg_sel = sel; wr_level = '0; rd_level = '0;
        wr_en = 0; rd_en = 0; ser_en = 0;
        tick();
        check("R9 near_full_n in reset", near_full_n, 1);
        check("R9 near_empty_n in reset", near_empty_n, 0);
        check("R9 dout in reset", dout, 0);
        tick();
        mrst_n = 1; cfg_sel = 0;
        m_ref = sel ? 1023 : 127; n_ref = m_ref;
        par_mode = sel; wseq = 0; rseq = 0; dout_ref = '0;
        tick();
    endtask

    task automatic par_write(logic [DATA_W-1:0] v);
        cfg_sel = 1; wr_en = 1; din = v;
        tick();
        cfg_sel = 0; wr_en = 0;
        if (par_mode) begin
            int off;
            int sh;
            sh  = (wseq % 2) * DATA_W;
            off = (wseq < 2) ? n_ref : m_ref;
            off = (off & ~(9'h1FF << sh)) | (int'(v) << sh);
            off = off & ((1 << OFS_W) - 1);
            if (wseq < 2) n_ref = off; else m_ref = off;
            wseq = (wseq + 1) % 4;
        end
    endtask

    task automatic read_slice(string req);
        cfg_sel = 1; rd_en = 1;
        tick();
        cfg_sel = 0; rd_en = 0;
        dout_ref = ref_slice(rseq);
        rseq = (rseq + 1) % 4;
        check(req, dout, dout_ref);
    endtask

    task automatic read_all(string req);
        for (int k = 0; k < 4; k++) read_slice(req);
    endtask

    task automatic ser_bit(bit b, bit en);
        ser_en = en; ser_in = b;
        tick();
        ser_en = 0;
        if (en && !par_mode) begin
            logic [2*OFS_W-1:0] c;
            c = {OFS_W'(m_ref), OFS_W'(n_ref)};
            c = {b, c[2*OFS_W-1:1]};
            m_ref = int'(c[2*OFS_W-1:OFS_W]);
            n_ref = int'(c[OFS_W-1:0]);
        end
    endtask

    task automatic check_flags(int wl, int rl, string req);
        wr_level = CNT_W'(wl); rd_level = CNT_W'(rl);
        tick();
        check({req, " near_full_n"}, near_full_n, exp_full_n(wl, m_ref));
        check({req, " near_empty_n"}, near_empty_n, exp_empty_n(rl, n_ref));
    endtask

    task automatic boundary_flags(string req);
        check_flags(DEPTH - m_ref, n_ref, req);
        check_flags(DEPTH - m_ref + 1, (n_ref > 0) ? n_ref - 1 : 0, req);
        check_flags(0, DEPTH, req);
        check_flags(DEPTH, 0, req);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd4711);
        @(negedge clk);

        // R1 parallel defaults
        do_mrst(1'b1);
        read_all("R1 default 1023 readback");
        boundary_flags("R2 R3 default 1023");

        // R4 R5 random parallel loads
        for (int i = 0; i < 20; i++) begin
            for (int k = 0; k < 4; k++) par_write(DATA_W'($urandom));
            read_all("R4 R5 parallel load readback");
            for (int j = 0; j < 4; j++)
                check_flags($urandom_range(DEPTH, 0), $urandom_range(DEPTH, 0), "R2 R3 random level");
            boundary_flags("R2 R3 programmed boundary");
        end

        // R5 dout holds while not reading
        read_slice("R5 single read");
        cfg_sel = 1; wr_en = 0; rd_en = 0;
        tick(); tick();
        cfg_sel = 0;
        rd_en = 1; tick(); rd_en = 0;
        check("R5 dout hold", dout, dout_ref);

        // R7 serial traffic ignored in parallel mode
        for (int i = 0; i < 12; i++) ser_bit(1'($urandom), 1'b1);
        read_all("R7 ser_en ignored in parallel mode");

        // R8 partial reset mid-sequence
        par_write(9'h155); par_write(9'h0AA);
        read_slice("R8 pre-partial read");
        prst_n = 0; tick(); prst_n = 1;
        wseq = 0; rseq = 0;
        read_all("R8 offsets kept after partial reset");
        par_write(9'h033);
        read_slice("R8 sequencer rewound to first slice");

        // R1 serial defaults
        do_mrst(1'b0);
        read_all("R1 default 127 readback");
        boundary_flags("R2 R3 default 127");

        // R7 parallel writes ignored in serial mode
        for (int k = 0; k < 4; k++) par_write(DATA_W'($urandom));
        read_all("R7 parallel write ignored in serial mode");

        // R6 serial loads, full and with gaps
        for (int i = 0; i < 10; i++) begin
            for (int b = 0; b < 2 * OFS_W; b++) ser_bit(1'($urandom), 1'b1);
            read_all("R6 serial load readback");
            boundary_flags("R2 R3 serial offsets");
            for (int b = 0; b < 11; b++) ser_bit(1'($urandom), 1'($urandom));
            read_all("R6 serial gaps readback");
        end

        // R8 partial reset keeps serial mode
        prst_n = 0; tick(); prst_n = 1; rseq = 0;
        for (int b = 0; b < 7; b++) ser_bit(1'($urandom), 1'b1);
        read_all("R8 serial mode kept after partial reset");

        finish_run();
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule